// File: doc/BRIEF.md
# Quad Serially-Programmed Digital Delay Line

This block holds four independent single-bit delay channels inside one synchronous clock domain. Each channel passes its input to its output without inversion. The output is shifted in time by a whole number of system clock cycles. That delay is a fixed base latency plus a 4-bit channel setting times a step size, and both the base and the step are parameters. Rising and falling edges take the same delay, so pulse widths come through unchanged.

A three-wire serial port sets up all four channels: a serial clock, serial data in, and a load strobe. A fourth wire, serial data out, lets several blocks share one port in a daisy chain. Bits go into a 20-bit holding register. A new setup takes effect only when the load strobe rises. Each channel has its own enable bit. A disabled channel drives its output low and clears its own history. The serial inputs may come from another clock domain: they pass through synchronizers, and the block acts on their rising edges.

Top module: `quad_delay_line`

## Requirements
- R1: After reset every channel is disabled with setting 0, `sig_o` is 0 whatever `sig_i` does, and `ser_dout_o` is 0.
- R2: An enabled channel with setting A (0..15) shows, after a clock edge, the value its input had D = BASE_LAT + A*STEP_LAT edges earlier. With the defaults BASE_LAT=2 and STEP_LAT=3, D runs from 2 to 47.
- R3: The output is a non-inverted copy of the input. Rising and falling edges get the same delay, so every pulse width is kept.
- R4: The four channels are independent. Each follows only its own input, its own setting and its own enable bit.
- R5: The holding register is 20 bits wide. It takes one bit per serial clock rise, shifting toward the MSB. Bit 19 is sent first. Channel 0 owns bits 19..15, channel 1 bits 14..10, channel 2 bits 9..5 and channel 3 bits 4..0. In each 5-bit field the top bit is the enable (1 = on), followed by the setting with its MSB first.
- R6: `ser_dout_o` always presents bit 19 of the holding register. A bit shifted in therefore appears there after 20 shifts, ready for the next block in a chain.
- R7: Shifting on its own changes no channel. The holding register is copied to the active setup only on a rising edge of `ser_latch_i`.
- R8: A disabled channel drives 0 and clears its delay history. When it is enabled again, no value it saw before or while disabled ever reaches its output.
- R9: The serial clock, data and strobe pass through synchronizers. Each rising edge of the serial clock causes exactly one shift, however long the serial clock stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din_i | input | 1 | Serial data in |
| ser_latch_i | input | 1 | Load strobe; its rising edge applies the holding register |
| ser_dout_o | output | 1 | Serial data out, MSB of the holding register |
| sig_i | input | 4 | Channel inputs, bit n feeds channel n |
| sig_o | output | 4 | Delayed channel outputs, bit n from channel n |

## Verification
The embedded properties check, on every cycle, the local mechanics:
- a serial clock rise produces exactly one shift, and the incoming bit lands in the register LSB;
- the active setup stays still unless a load strobe edge arrives;
- an enabled channel's first pipeline stage follows its input;
- a channel that has just been re-enabled drives low.

The end-to-end delay values can only be shown by the bench's scenarios. These cover the full range of settings on all four channels with different per-channel delays, the bit order on the daisy-chain output, and the absence of stale edges after a disable and re-enable.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

    localparam int unsigned NUM_CH  = 4;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned FIELD_W = ADDR_W + 1;
    localparam int unsigned WORD_W  = NUM_CH * FIELD_W;
    localparam int unsigned MAX_SEL = (1 << ADDR_W) - 1;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] sel;
    } chan_cfg_t;

endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.st = {state_q.st[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign sync_o = state_q.st[STAGES-1];

endmodule

// File: rtl/qdl_cfg_shift.sv
module qdl_cfg_shift
    import qdl_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sclk_i,
    input  logic                   sdin_i,
    input  logic                   slat_i,
    output logic                   sdout_o,
    output chan_cfg_t [NUM_CH-1:0] cfg_o
);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] active;
        logic              sclk_prev;
        logic              slat_prev;
    } shift_state_t;

    shift_state_t state_d, state_q;
    logic         shift_pulse;
    logic         load_pulse;

    always_comb begin
        state_d           = state_q;
        shift_pulse       = sclk_i & ~state_q.sclk_prev;
        load_pulse        = slat_i & ~state_q.slat_prev;
        state_d.sclk_prev = sclk_i;
        state_d.slat_prev = slat_i;
        if (shift_pulse) state_d.hold   = {state_q.hold[WORD_W-2:0], sdin_i};
        if (load_pulse)  state_d.active = state_q.hold;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign sdout_o = state_q.hold[WORD_W-1];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_field
        assign cfg_o[k] = state_q.active[WORD_W-1-k*FIELD_W -: FIELD_W];
    end

    AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_pulse |=> (state_q.hold[0] == $past(sdin_i))
                        && (state_q.hold[WORD_W-1:1] == $past(state_q.hold[WORD_W-2:0]))); // R5

    AST_ONE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_pulse |=> !shift_pulse); // R9

    AST_LOAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_pulse |=> $stable(state_q.active)); // R7

endmodule

// File: rtl/qdl_chan.sv
module qdl_chan
    import qdl_pkg::*;
#(
    parameter int unsigned BASE_LAT = 2,
    parameter int unsigned STEP_LAT = 3
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  chan_cfg_t cfg_i,
    input  logic      din_i,
    output logic      dout_o
);

    localparam int unsigned DEPTH = BASE_LAT + MAX_SEL * STEP_LAT;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } chan_state_t;

    chan_state_t      state_d, state_q;
    logic [IDX_W-1:0] tap;

    always_comb begin
        state_d = state_q;
        if (!cfg_i.en) state_d.pipe = '0;
        else           state_d.pipe = {state_q.pipe[DEPTH-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        tap    = IDX_W'(BASE_LAT - 1) + IDX_W'(cfg_i.sel) * IDX_W'(STEP_LAT);
        dout_o = cfg_i.en ? state_q.pipe[tap] : 1'b0;
    end

    AST_FIRST_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.en && $past(cfg_i.en)) |-> (state_q.pipe[0] == $past(din_i))); // R3

    AST_REENABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_i.en) |-> (dout_o == 1'b0)); // R8

endmodule

// File: rtl/quad_delay_line.sv
module quad_delay_line
    import qdl_pkg::*;
#(
    parameter int unsigned BASE_LAT    = 2,
    parameter int unsigned STEP_LAT    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              ser_latch_i,
    output logic              ser_dout_o,
    input  logic [NUM_CH-1:0] sig_i,
    output logic [NUM_CH-1:0] sig_o
);

    logic [2:0]             ser_sync;
    chan_cfg_t [NUM_CH-1:0] cfg;

    qdl_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .async_i ({ser_latch_i, ser_din_i, ser_clk_i}),
        .sync_o  (ser_sync)
    );

    qdl_cfg_shift u_cfg (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .sclk_i  (ser_sync[0]),
        .sdin_i  (ser_sync[1]),
        .slat_i  (ser_sync[2]),
        .sdout_o (ser_dout_o),
        .cfg_o   (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        qdl_chan #(
            .BASE_LAT (BASE_LAT),
            .STEP_LAT (STEP_LAT)
        ) u_chan (
            .clk_i  (clk),
            .rst_ni (rst_n),
            .cfg_i  (cfg[c]),
            .din_i  (sig_i[c]),
            .dout_o (sig_o[c])
        );
    end

endmodule

// File: tb/sim_quad_delay_line.sv
module sim_quad_delay_line;

    localparam int BASE = 2;
    localparam int STEP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_latch = 1'b0;
    logic       ser_dout;
    logic [3:0] sig_in = 4'h0;
    logic [3:0] sig_out;
    logic [15:0] lfsr = 16'hACE1;
    logic [3:0] hist [0:1023];
    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    quad_delay_line #(.BASE_LAT(BASE), .STEP_LAT(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
        .ser_latch_i(ser_latch), .ser_dout_o(ser_dout), .sig_i(sig_in), .sig_o(sig_out));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int hi);
        ser_din = b; cyc(4);
        ser_clk = 1'b1; cyc(hi);
        ser_clk = 1'b0; cyc(4);
    endtask

    task automatic send_word(input logic [19:0] w);
        for (int i = 19; i >= 0; i--) send_bit(w[i], 4);
    endtask

    task automatic do_latch();
        ser_latch = 1'b1; cyc(4);
        ser_latch = 1'b0; cyc(6);
    endtask

    function automatic logic [19:0] mk(input logic [3:0] en, input logic [3:0] a0,
                                       input logic [3:0] a1, input logic [3:0] a2,
                                       input logic [3:0] a3);
        return {en[0], a0, en[1], a1, en[2], a2, en[3], a3};
    endfunction

    // Inputs are held at 0 before the call, so every pipeline holds zeros.
    task automatic run_pattern(input int n, input logic [3:0] en, input int d [4], input string req);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                logic e;
                e = (en[c] && j >= d[c]) ? hist[j - d[c]][c] : 1'b0;
                chk(sig_out[c] == e, req, int'(sig_out[c]), int'(e));
            end
            sig_in = lfsr[3:0];
            hist[j] = sig_in;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        sig_in = 4'h0;
        cyc(2);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog expired actual=0 expected=1");
        n_vec++; n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int d [4];
        logic [3:0] a [4];
        logic [19:0] w;

        // R1: reset state
        sig_in = 4'hF;
        cyc(3); rst_n = 1'b1; cyc(3);
        chk(sig_out == 4'h0, "R1 outputs low", int'(sig_out), 0);
        chk(ser_dout == 1'b0, "R1 serial out low", int'(ser_dout), 0);
        cyc(50);
        chk(sig_out == 4'h0, "R1 disabled after reset", int'(sig_out), 0);
        sig_in = 4'h0; cyc(2);

        // R2 R4 R3 R5: sweep every setting, with distinct settings per channel
        for (int s = 0; s < 16; s++) begin
            a[0] = 4'(s); a[1] = 4'((s + 5) & 15); a[2] = 4'(15 - s); a[3] = 4'((s * 7) & 15);
            for (int c = 0; c < 4; c++) d[c] = BASE + int'(a[c]) * STEP;
            send_word(20'h0); do_latch();
            send_word(mk(4'hF, a[0], a[1], a[2], a[3])); do_latch();
            run_pattern(BASE + 15 * STEP + 20, 4'hF, d, "R2 R3 R4 delay sweep");
        end

        // R8 R4: a mix of enabled and disabled channels
        send_word(20'h0); do_latch();
        send_word(mk(4'b0101, 4'd3, 4'd3, 4'd9, 4'd9)); do_latch();
        d[0] = BASE + 3 * STEP; d[1] = d[0]; d[2] = BASE + 9 * STEP; d[3] = d[2];
        run_pattern(70, 4'b0101, d, "R8 R4 partial enable");

        // R7: shifting without the strobe leaves the running setup alone
        send_word(mk(4'hF, 4'd4, 4'd4, 4'd4, 4'd4)); do_latch();
        sig_in = 4'hF; cyc(60);
        chk(sig_out == 4'hF, "R2 steady high", int'(sig_out), 15);
        send_word(20'h0);
        chk(sig_out == 4'hF, "R7 no change without strobe", int'(sig_out), 15);
        do_latch();
        chk(sig_out == 4'h0, "R8 disabled drives low", int'(sig_out), 0);
        cyc(20);
        chk(sig_out == 4'h0, "R8 stays low", int'(sig_out), 0);

        // R8: re-enable must show no stale history
        sig_in = 4'h0;
        send_word(mk(4'hF, 4'd4, 4'd4, 4'd4, 4'd4)); do_latch();
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            chk(sig_out == 4'h0, "R8 no stale edges", int'(sig_out), 0);
        end

        // R7: shift an all-enabled word with no strobe, outputs stay low
        send_word(20'h0); do_latch();
        send_word(mk(4'hF, 4'd0, 4'd0, 4'd0, 4'd0));
        sig_in = 4'hF; cyc(40);
        chk(sig_out == 4'h0, "R7 shift alone has no effect", int'(sig_out), 0);
        sig_in = 4'h0;

        // R6 R9: long serial clock highs, then read back through the serial out
        w = 20'hB5C3A;
        for (int i = 19; i >= 0; i--) send_bit(w[i], 25);
        for (int k = 0; k < 20; k++) begin
            chk(ser_dout == w[19 - k], "R6 R9 serial out order", int'(ser_dout), int'(w[19 - k]));
            send_bit(1'b0, 4);
        end
        chk(ser_dout == 1'b0, "R6 shifted out fully", int'(ser_dout), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule